// File: doc/BRIEF.md
# Serial Transmitter with Idle and Break Queuing

This block is the transmit half of an asynchronous serial port. It takes bytes (or 9-bit words) from a one-entry holding register and shifts them out least significant bit first. Each frame has a start bit of 0, the data bits and one or two stop bits of 1. Every bit lasts exactly one pulse of an external baud tick. A new character always begins on a tick, so characters follow each other with no gap.

Besides data, the transmitter places two special characters into its output stream. An idle character is a whole frame time of 1s. It is queued when the enable input is dropped and raised again while a character is on the line. A break character is a run of 0s. It is queued by a rising edge of the break request, and it repeats back to back for as long as the request stays high. When the enable is cleared, the block keeps owning the line until everything already accepted has gone out, and only then drops its output enable. A single-wire mode hands the direction of the line to a separate direction bit.

Top module: `sertx_core`

## Requirements
- R1: After reset, with `tx_en` low, `tx_out` is 1, `busy` is 0 and `tx_oe` is 0.
- R2: A data frame is a 0 start bit, then the data bits LSB first, then stop bits of 1. With `nine_bit`=0 the data is `wr_data[7:0]`. With `nine_bit`=1, `wr_data[8]` follows as a ninth bit. `two_stop`=1 adds a second stop bit. Every bit lasts one `baud_tick`, and a character starts only on a tick.
- R3: A write is taken only while `tx_en` is 1 and the holding register is empty. A write while it is full, or while `tx_en` is 0, is ignored. A byte that waits in the holding register goes out right after the current character, with no gap between them.
- R4: A rising edge of `tx_en` while a character is on the line queues one idle character: 1s for 10 + `nine_bit` + `two_stop` bit times.
- R5: A rising edge of `brk_req` while `tx_en` is 1 queues one break: 0s for 10 + `nine_bit` + `two_stop` bit times, plus 3 when `brk_long` is 1.
- R6: While `brk_req` stays 1 with `tx_en` high, break characters repeat back to back. The total run of 0s is a whole number of break lengths.
- R7: When a character ends, the next one is chosen in this order: pending data, then a queued idle, then a break.
- R8: After `tx_en` is cleared, `tx_oe` stays 1 until all accepted work has been sent (`busy` falls). Queued characters are still sent. After that, `tx_oe` is 0.
- R9: With `single_wire`=1, `tx_oe` is 1 only when `dir_out` is 1 and the line is owned. With `single_wire`=0, `tx_oe` follows ownership (`tx_en` or `busy`).
- R10: `busy` is 1 from the cycle after an accepted write or break request until the last bit of queued work has finished. While `busy` is 0, `tx_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Word to send; bit 8 is used only in 9-bit mode |
| tx_en | input | 1 | Transmitter enable |
| brk_req | input | 1 | Break request level |
| brk_long | input | 1 | Adds 3 bit times to each break |
| nine_bit | input | 1 | Selects 9 data bits |
| two_stop | input | 1 | Selects a second stop bit |
| single_wire | input | 1 | Single-wire mode; direction comes from dir_out |
| dir_out | input | 1 | Line direction in single-wire mode (1 = drive) |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| tx_out | output | 1 | Serial line |
| tx_oe | output | 1 | Output enable for the line |
| busy | output | 1 | Work in flight or queued |

## Verification
The bench sweeps every frame format, sending all 256 byte values in the plain 8-bit format and a spread of 9-bit words in the others. A wrong bit order or a wrong count of stop bits shows up there as a frame mismatch. A break length that ignores the format or the long-break bit gives a wrong run of 0s. A pulse that lines up with a tick and is counted twice shows up as a second break. A mixed stream of data, pending data, a toggled enable and a break pulse tests the service order and the idle length. An idle that is too short, too long, or sent ahead of pending data moves the break to the wrong place. Clearing the enable in the middle of a frame tests that the output enable is held and then dropped. A design that lets go of the line early would cut the frame short.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int unsigned DATA_W = 9;
  localparam int unsigned SH_W   = 16;
  localparam int unsigned LEN_W  = 5;
  localparam int unsigned BASE_LEN = 10;
  localparam int unsigned LONG_ADD = 3;

  typedef enum logic [1:0] {
    K_NONE  = 2'd0,
    K_DATA  = 2'd1,
    K_IDLE  = 2'd2,
    K_BREAK = 2'd3
  } txq_kind_e;

  // number of bit times in one data frame (also the idle length)
  function automatic logic [LEN_W-1:0] frame_len(input logic nine, input logic two_stop);
    return LEN_W'(BASE_LEN) + LEN_W'(nine) + LEN_W'(two_stop);
  endfunction

  // number of zero bit times in one break character
  function automatic logic [LEN_W-1:0] break_len(input logic nine, input logic two_stop,
                                                 input logic long_brk);
    return frame_len(nine, two_stop) + (long_brk ? LEN_W'(LONG_ADD) : LEN_W'(0));
  endfunction

  // shift word for a data frame, bit 0 leaves first
  function automatic logic [SH_W-1:0] frame_word(input logic [DATA_W-1:0] d, input logic nine);
    logic [SH_W-1:0] w;
    w = '1;
    w[0] = 1'b0;
    w[DATA_W-1:1] = d[DATA_W-2:0];
    if (nine) w[DATA_W] = d[DATA_W-1];
    return w;
  endfunction
endpackage

// File: rtl/sertx_hold.sv
module sertx_hold
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              accept_en,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  logic wr_ok;
  assign wr_ok = wr_stb & accept_en & ~full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (wr_ok) begin
        full <= 1'b1;
        data <= wr_data;
      end else if (take) begin
        full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sertx_sched.sv
module sertx_sched
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              tx_en,
  input  logic              brk_req,
  input  logic              brk_long,
  input  logic              nine_bit,
  input  logic              two_stop,
  input  logic              eng_active,
  input  logic              eng_last,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  output logic              take_data,
  output logic              load,
  output logic [SH_W-1:0]   load_word,
  output logic [LEN_W-1:0]  load_len,
  output txq_kind_e         load_kind,
  output logic              idle_q,
  output logic              brk_q
);
  logic te_d, brk_d;
  logic te_rise, brk_rise;
  logic start_ok, want_brk;
  logic take_idle, take_brk;
  logic set_idle, set_brk;

  assign te_rise  = tx_en & ~te_d;
  assign brk_rise = brk_req & ~brk_d;
  assign start_ok = baud_tick & (~eng_active | eng_last);
  assign want_brk = brk_q | (brk_req & tx_en);

  assign take_data = start_ok & hold_full;
  assign take_idle = start_ok & ~hold_full & idle_q;
  assign take_brk  = start_ok & ~hold_full & ~idle_q & want_brk;
  assign load      = take_data | take_idle | take_brk;

  assign set_idle = te_rise & eng_active;
  assign set_brk  = brk_rise & tx_en & ~take_brk;

  always_comb begin
    load_word = '1;
    load_len  = frame_len(nine_bit, two_stop);
    load_kind = K_NONE;
    if (take_data) begin
      load_word = frame_word(hold_data, nine_bit);
      load_kind = K_DATA;
    end else if (take_idle) begin
      load_kind = K_IDLE;
    end else if (take_brk) begin
      load_word = '0;
      load_len  = break_len(nine_bit, two_stop, brk_long);
      load_kind = K_BREAK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      te_d   <= 1'b0;
      brk_d  <= 1'b0;
      idle_q <= 1'b0;
      brk_q  <= 1'b0;
    end else begin
      te_d   <= tx_en;
      brk_d  <= brk_req;
      idle_q <= (idle_q & ~take_idle) | set_idle;
      brk_q  <= (brk_q & ~take_brk) | set_brk;
    end
  end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             baud_tick,
  input  logic             load,
  input  logic [SH_W-1:0]  load_word,
  input  logic [LEN_W-1:0] load_len,
  input  txq_kind_e        load_kind,
  output logic             active,
  output logic             last,
  output txq_kind_e        cur_kind,
  output logic             line
);
  logic [SH_W-1:0]  sh;
  logic [LEN_W-1:0] cnt;

  assign last = active & baud_tick & (cnt == LEN_W'(1));
  assign line = active ? sh[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh       <= '1;
      cnt      <= '0;
      active   <= 1'b0;
      cur_kind <= K_NONE;
    end else if (load) begin
      sh       <= load_word;
      cnt      <= load_len;
      active   <= 1'b1;
      cur_kind <= load_kind;
    end else if (baud_tick && active) begin
      sh  <= {1'b1, sh[SH_W-1:1]};
      cnt <= cnt - LEN_W'(1);
      if (cnt == LEN_W'(1)) begin
        active   <= 1'b0;
        cur_kind <= K_NONE;
      end
    end
  end
endmodule

// File: rtl/sertx_core.sv
module sertx_core
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_en,
  input  logic              brk_req,
  input  logic              brk_long,
  input  logic              nine_bit,
  input  logic              two_stop,
  input  logic              single_wire,
  input  logic              dir_out,
  input  logic              baud_tick,
  output logic              tx_out,
  output logic              tx_oe,
  output logic              busy
);
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              take_data;
  logic              eng_load;
  logic [SH_W-1:0]   load_word;
  logic [LEN_W-1:0]  load_len;
  txq_kind_e         load_kind;
  txq_kind_e         cur_kind;
  logic              idle_q, brk_q;
  logic              eng_active, eng_last;
  logic              own_line;

  sertx_hold u_hold (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .accept_en(tx_en), .take(take_data), .full(hold_full), .data(hold_data)
  );

  sertx_sched u_sched (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
    .brk_req(brk_req), .brk_long(brk_long), .nine_bit(nine_bit), .two_stop(two_stop),
    .eng_active(eng_active), .eng_last(eng_last), .hold_full(hold_full),
    .hold_data(hold_data), .take_data(take_data), .load(eng_load),
    .load_word(load_word), .load_len(load_len), .load_kind(load_kind),
    .idle_q(idle_q), .brk_q(brk_q)
  );

  sertx_shift u_shift (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .load(eng_load),
    .load_word(load_word), .load_len(load_len), .load_kind(load_kind),
    .active(eng_active), .last(eng_last), .cur_kind(cur_kind), .line(tx_out)
  );

  assign busy     = eng_active | hold_full | idle_q | brk_q;
  assign own_line = tx_en | busy;
  assign tx_oe    = own_line & (~single_wire | dir_out);
endmodule

// File: rtl/sertx_checker.sv
module sertx_checker
  import sertx_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      baud_tick,
  input logic      tx_out,
  input logic      tx_oe,
  input logic      busy,
  input logic      single_wire,
  input logic      dir_out,
  input logic      eng_active,
  input logic      eng_load,
  input txq_kind_e load_kind,
  input txq_kind_e cur_kind,
  input logic      hold_full
);
  AST_QUIET_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> tx_out); // R10
  AST_OE_HELD: assert property (@(posedge clk) disable iff (!rst_n) (busy && !single_wire) |-> tx_oe); // R8
  AST_SW_DIR_LOW: assert property (@(posedge clk) disable iff (!rst_n) (single_wire && !dir_out) |-> !tx_oe); // R9
  AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) !$past(baud_tick) |-> $stable(tx_out)); // R2
  AST_START_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) $rose(eng_active) |-> $past(baud_tick)); // R2
  AST_DATA_FIRST: assert property (@(posedge clk) disable iff (!rst_n) (eng_load && load_kind != K_DATA) |-> !hold_full); // R7
  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n) (cur_kind == K_BREAK) |-> !tx_out); // R5
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (cur_kind == K_IDLE) |-> tx_out); // R4
endmodule

bind sertx_core sertx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_out(tx_out), .tx_oe(tx_oe),
  .busy(busy), .single_wire(single_wire), .dir_out(dir_out), .eng_active(eng_active),
  .eng_load(eng_load), .load_kind(load_kind), .cur_kind(cur_kind), .hold_full(hold_full)
);

// File: tb/sim_sertx_core.sv
`timescale 1ns/1ps
module sim_sertx_core;
  localparam int TICK_DIV = 4;
  localparam int LOG_N    = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_stb = 1'b0;
  logic [8:0] wr_data = '0;
  logic tx_en = 1'b0, brk_req = 1'b0, brk_long = 1'b0;
  logic nine_bit = 1'b0, two_stop = 1'b0, single_wire = 1'b0, dir_out = 1'b0;
  logic baud_tick = 1'b0;
  logic tx_out, tx_oe, busy;

  int tests = 0;
  int fails = 0;
  int phase = 0;
  int lp = 0;
  logic [1:0] tlog [LOG_N];

  always #2.5 clk = ~clk;

  sertx_core u0 (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data), .tx_en(tx_en),
    .brk_req(brk_req), .brk_long(brk_long), .nine_bit(nine_bit), .two_stop(two_stop),
    .single_wire(single_wire), .dir_out(dir_out), .baud_tick(baud_tick),
    .tx_out(tx_out), .tx_oe(tx_oe), .busy(busy)
  );

  // record the line once per bit time, then schedule the next tick
  always @(negedge clk) begin
    if (baud_tick) begin
      tlog[lp % LOG_N] = {tx_out, tx_oe};
      lp = lp + 1;
    end
    phase = (phase + 1) % TICK_DIV;
    baud_tick = (phase == 0);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int line_at(input int i);
    return int'(tlog[i % LOG_N][1]);
  endfunction

  function automatic int find_zero(input int from);
    for (int i = from; i < lp; i++) if (line_at(i) == 0) return i;
    return -1;
  endfunction

  function automatic int flen(input bit n, input bit t);
    return 10 + int'(n) + int'(t);
  endfunction

  // expected k-th bit of a data frame, built as an integer word
  function automatic int fbit(input int d, input bit n, input bit t, input int k);
    int nb, w;
    nb = n ? 9 : 8;
    w = ((d & ((1 << nb) - 1)) << 1) | (((1 << (2 + int'(t))) - 1) << (1 + nb));
    return (w >> k) & 1;
  endfunction

  task automatic write_word(input int d);
    wr_stb = 1'b1;
    wr_data = 9'(d);
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic wait_quiet;
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (TICK_DIV * 4) @(negedge clk);
  endtask

  task automatic wait_start;
    while (tx_out) @(negedge clk);
  endtask

  // compares a data frame at log index s, returns mismatches
  function automatic int cmp_frame(input int s, input int d, input bit n, input bit t);
    int bad = 0;
    for (int k = 0; k < flen(n, t); k++) if (line_at(s + k) != fbit(d, n, t, k)) bad++;
    return bad;
  endfunction

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    int mark, s, z, bad, d, exp_len;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(tx_out == 1'b1, "R1 line high in reset", int'(tx_out), 1);
    chk(busy == 1'b0, "R1 busy low in reset", int'(busy), 0);
    chk(tx_oe == 1'b0, "R1 oe low in reset", int'(tx_oe), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(tx_out == 1'b1 && busy == 1'b0 && tx_oe == 1'b0, "R1 after reset release", int'(busy), 0);

    // R3: writes ignored while disabled
    mark = lp;
    write_word(9'h0A5);
    repeat (TICK_DIV * 15) @(negedge clk);
    chk(busy == 1'b0 && find_zero(mark) == -1, "R3 write ignored when disabled", int'(busy), 0);

    tx_en = 1'b1;
    @(negedge clk);
    // R10: busy rises right after an accepted write
    write_word(9'h03C);
    chk(busy == 1'b1, "R10 busy after write", int'(busy), 1);
    wait_quiet();
    chk(busy == 1'b0 && tx_out == 1'b1, "R10 quiet after frame", int'(busy), 0);

    // R2: frame sweep over all formats
    for (int f = 0; f < 4; f++) begin
      nine_bit = f[0];
      two_stop = f[1];
      bad = 0;
      for (int i = 0; i < ((f == 0) ? 256 : 40); i++) begin
        d = (f == 0) ? i : ((i * 37 + 5) % 512);
        mark = lp;
        write_word(d);
        wait_quiet();
        s = find_zero(mark);
        if (s < 0 || cmp_frame(s, d, nine_bit, two_stop) != 0 ||
            find_zero(s + flen(nine_bit, two_stop)) != -1) bad++;
      end
      chk(bad == 0, "R2 frame format sweep", bad, 0);
    end

    // R3: pending word follows with no gap, third write ignored
    nine_bit = 1'b0; two_stop = 1'b0;
    mark = lp;
    write_word(9'h055);
    wait_start();
    write_word(9'h0F0);
    write_word(9'h000);
    wait_quiet();
    s = find_zero(mark);
    bad = cmp_frame(s, 9'h055, 1'b0, 1'b0) + cmp_frame(s + 10, 9'h0F0, 1'b0, 1'b0);
    chk(bad == 0, "R3 back to back frames", bad, 0);
    chk(find_zero(s + 20) == -1, "R3 write while full ignored", find_zero(s + 20), -1);

    // R5: single break length for every format and length option
    for (int f = 0; f < 8; f++) begin
      nine_bit = f[0]; two_stop = f[1]; brk_long = f[2];
      exp_len = flen(nine_bit, two_stop) + (brk_long ? 3 : 0);
      mark = lp;
      brk_req = 1'b1;
      @(negedge clk);
      brk_req = 1'b0;
      wait_quiet();
      s = find_zero(mark);
      z = 0;
      while (s >= 0 && s + z < lp && line_at(s + z) == 0) z++;
      chk(z == exp_len && find_zero(s + z) == -1, "R5 break length", z, exp_len);
    end

    // R5: pulse aligned with a tick still gives one break
    nine_bit = 1'b0; two_stop = 1'b0; brk_long = 1'b0;
    mark = lp;
    while (phase != TICK_DIV - 1) @(negedge clk);
    brk_req = 1'b1;
    @(negedge clk);
    brk_req = 1'b0;
    wait_quiet();
    s = find_zero(mark);
    z = 0;
    while (s >= 0 && s + z < lp && line_at(s + z) == 0) z++;
    chk(z == 10, "R5 tick aligned pulse single break", z, 10);

    // R6: held request repeats breaks
    mark = lp;
    brk_req = 1'b1;
    repeat (TICK_DIV * 25) @(negedge clk);
    brk_req = 1'b0;
    wait_quiet();
    s = find_zero(mark);
    z = 0;
    while (s >= 0 && s + z < lp && line_at(s + z) == 0) z++;
    chk(z >= 20 && (z % 10) == 0, "R6 repeated breaks", z, 30);

    // R4 and R7: data, pending data, idle, break in that order
    mark = lp;
    write_word(9'h0C3);
    wait_start();
    write_word(9'h01E);
    tx_en = 1'b0;
    @(negedge clk);
    tx_en = 1'b1;
    brk_req = 1'b1;
    @(negedge clk);
    brk_req = 1'b0;
    wait_quiet();
    s = find_zero(mark);
    bad = cmp_frame(s, 9'h0C3, 1'b0, 1'b0) + cmp_frame(s + 10, 9'h01E, 1'b0, 1'b0);
    chk(bad == 0, "R7 data before idle and break", bad, 0);
    bad = 0;
    for (int k = 20; k < 30; k++) if (line_at(s + k) != 1) bad++;
    for (int k = 30; k < 40; k++) if (line_at(s + k) != 0) bad++;
    chk(bad == 0, "R4 idle of frame length before break", bad, 0);
    chk(find_zero(s + 40) == -1, "R4 single idle and break", find_zero(s + 40), -1);

    // R8: enable cleared mid frame keeps the line
    nine_bit = 1'b1; two_stop = 1'b1;
    mark = lp;
    write_word(9'h1A7);
    wait_start();
    tx_en = 1'b0;
    bad = 0;
    @(negedge clk);
    while (busy) begin
      if (!tx_oe) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R8 oe held while draining", bad, 0);
    chk(tx_oe == 1'b0, "R8 oe released after drain", int'(tx_oe), 0);
    s = find_zero(mark);
    chk(cmp_frame(s, 9'h1A7, 1'b1, 1'b1) == 0, "R8 frame completes after disable",
        cmp_frame(s, 9'h1A7, 1'b1, 1'b1), 0);

    // R9: single-wire direction
    tx_en = 1'b1; single_wire = 1'b1; dir_out = 1'b0;
    @(negedge clk);
    chk(tx_oe == 1'b0, "R9 single wire receive direction", int'(tx_oe), 0);
    dir_out = 1'b1;
    @(negedge clk);
    chk(tx_oe == 1'b1, "R9 single wire drive direction", int'(tx_oe), 1);
    single_wire = 1'b0; dir_out = 1'b0;
    @(negedge clk);
    chk(tx_oe == 1'b1, "R9 normal mode follows enable", int'(tx_oe), 1);
    tx_en = 1'b0;
    @(negedge clk);
    chk(tx_oe == 1'b0, "R9 normal mode released", int'(tx_oe), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule